// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block moves stereo audio between a parallel sample interface and a three-wire serial line: a bit clock, a word-select line and one data line. One control bit picks transmit or receive. When it owns the line (master), it makes the bit clock from the system clock and toggles word select itself. When another device owns the line (slave), it brings the external bit clock, word select and data into the system clock domain and detects the clock edges there. Each channel carries one 16-bit word, most significant bit first. The first bit of a word goes out one bit clock after the word-select change that opens it.

The control word is set at run time. It holds separate direction bits for the bit clock and for word select, the bit clock edge that launches data, the word-select level that marks the first channel, and the bit clock half period. If the two direction bits disagree, the port stops driving all pins and ignores the line. A sticky error flag records this until reset. On the parallel side, transmit takes a left/right pair through a valid/ready handshake. Receive presents each completed pair with a one-cycle valid pulse.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the control word reads 0. A write stores all 16 bits, and the readback `ctrlQ` returns the written value from the cycle after the write. Bit 15 = bit clock drive, bit 14 = word-select drive, bit 13 = launch-edge select, bit 12 = word-select polarity, bits 11:8 = bit clock half period in system clocks, bit 0 = transmit mode. Bits 7:1 have no effect.
- R2: With bits 15 and 14 both 1, `sckOe` and `wsOe` are 1. The bit clock period is 2*max(half,2) system clocks. Word select changes every 16 bit clocks. With both bits 0, neither output enable is set.
- R3: With bit 13 = 0, word select and transmit data change only with a falling bit clock edge and are sampled on the rising edge. With bit 13 = 1, they change with the rising edge and are sampled on the falling edge.
- R4: With bit 12 = 0, word select is low for the first (left) channel and high for the second (right). With bit 12 = 1, the levels are swapped. In master mode word select starts in the first channel right after a control write.
- R5: Each word is sent and received MSB first. Its MSB sits in the bit slot that follows the word-select change opening it, and its LSB shares a slot with the next word-select change.
- R6: In receive mode, the cycle after a left word and the following right word are complete, `rxValid` is high for exactly one cycle with `rxLeft`/`rxRight` holding them. A right word with no left word before it since the last control write produces no pulse.
- R7: In transmit mode, `txReady` is high while the one-pair holding register is empty. It drops the cycle after a pair is accepted. The held pair starts going out at the next change into the first channel.
- R8: If the holding register is empty at a change into the first channel, the sticky `underrun` flag sets and that whole pair goes out as zeros. A control write clears the flag.
- R9: While bits 15 and 14 differ, `sckOe`, `wsOe` and `sdOe` are 0 and no samples are received. `cfgErr` sets the cycle after the control word holds such a value and stays set until reset.
- R10: `sdOe` is 1 only in transmit mode with a legal direction setting. In transmit mode `rxValid` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 16 | Control word write value |
| ctrlQ | output | 16 | Control word readback |
| sckIn | input | 1 | Bit clock from the line (slave) |
| sckOut | output | 1 | Generated bit clock (master) |
| sckOe | output | 1 | Bit clock output enable |
| wsIn | input | 1 | Word select from the line (slave) |
| wsOut | output | 1 | Generated word select (master) |
| wsOe | output | 1 | Word select output enable |
| sdIn | input | 1 | Serial data from the line |
| sdOut | output | 1 | Serial data to the line |
| sdOe | output | 1 | Serial data output enable |
| txValid | input | 1 | Transmit pair offered |
| txReady | output | 1 | Holding register empty |
| txLeft | input | 16 | Transmit first-channel word |
| txRight | input | 16 | Transmit second-channel word |
| rxValid | output | 1 | One-cycle pulse: received pair ready |
| rxLeft | output | 16 | Received first-channel word |
| rxRight | output | 16 | Received second-channel word |
| underrun | output | 1 | Sticky transmit underrun flag |
| cfgErr | output | 1 | Sticky illegal direction flag |

## Verification
Control readback is due one cycle after a write and `cfgErr` two cycles after. The bench samples those at the following falling system clock edges. Serial results have no fixed latency relative to the parallel side, so the bench does not wait a set number of cycles for them. For transmit, it decodes the pins at each sampling-type bit clock edge, the way a line partner would, and pops the expected pair from a queue at each change into the first channel. For receive, a monitor pops a queue whenever `rxValid` appears: two synchronizer flops, the edge detector and the output register put that pulse a few system cycles after the final sampling edge, and an extra or missing pulse shows up as a queue mismatch.

// File: rtl/asp_pkg.sv
package asp_pkg;
  // Strobes from the line controller to the datapath, all valid for one clk.
  typedef struct packed {
    logic restart;   // control word written: restart framing
    logic launch;    // edge on which outgoing bits change
    logic capture;   // edge on which line bits are sampled
    logic wsChan;    // current channel on the line: 0 first, 1 second
    logic sdBit;     // data line value to sample
  } asp_strobe_t;
endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWe,
  input  logic [15:0] ctrlWdata,
  output logic [15:0] ctrlQ,
  input  logic        sckIn,
  input  logic        wsIn,
  input  logic        sdIn,
  output logic        sckOut,
  output logic        sckOe,
  output logic        wsOut,
  output logic        wsOe,
  output logic        sdOe,
  output logic        txMode,
  output logic        cfgErr,
  output asp_strobe_t stb
);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam int HALF_W   = 4;
  localparam int MIN_HALF = 2;
  localparam int LINES    = 3;

  logic [15:0] ctrlReg;
  logic sckDrive, wsDrive, sckPol, wsPol;
  logic [HALF_W-1:0] halfField, halfEff;
  logic legal, master, slave;

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWdata;
  end

  assign ctrlQ     = ctrlReg;
  assign sckDrive  = ctrlReg[15];
  assign wsDrive   = ctrlReg[14];
  assign sckPol    = ctrlReg[13];
  assign wsPol     = ctrlReg[12];
  assign halfField = ctrlReg[11:8];
  assign txMode    = ctrlReg[0];
  assign legal     = (sckDrive == wsDrive);
  assign master    = legal && sckDrive;
  assign slave     = legal && !sckDrive;
  assign halfEff   = (halfField < HALF_W'(MIN_HALF)) ? HALF_W'(MIN_HALF) : halfField;

  always_ff @(posedge clk) begin
    if (!rstN)       cfgErr <= 1'b0;
    else if (!legal) cfgErr <= 1'b1;
  end

  // Master clock and word-select generation
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic sckM, wsChanM, tick, mLaunch, mCapture;

  assign tick     = master && !ctrlWe && (halfCnt == halfEff - 1'b1);
  assign mLaunch  = tick && ((~sckM) == sckPol);
  assign mCapture = tick && ((~sckM) != sckPol);

  always_ff @(posedge clk) begin
    if (!rstN || ctrlWe || !master) begin
      halfCnt <= '0;
      bitCnt  <= '0;
      sckM    <= 1'b0;
      wsChanM <= 1'b0;
    end else begin
      if (tick) begin
        halfCnt <= '0;
        sckM    <= ~sckM;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
      if (mLaunch) begin
        if (bitCnt == BIT_W'(WORD_W - 1)) begin
          bitCnt  <= '0;
          wsChanM <= ~wsChanM;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // Slave line synchronizers, one chain per line
  logic [LINES-1:0] rawLines, syncLines;
  assign rawLines = {sckIn, wsIn, sdIn};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawLines[g]};
      end
      assign syncLines[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  logic sckS, wsS, sdS, sckPrev, sEdge, sLaunch, sCapture;
  assign {sckS, wsS, sdS} = syncLines;

  always_ff @(posedge clk) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sEdge    = slave && !ctrlWe && (sckS != sckPrev);
  assign sLaunch  = sEdge && (sckS == sckPol);
  assign sCapture = sEdge && (sckS != sckPol);

  always_comb begin
    stb.restart = ctrlWe;
    stb.launch  = mLaunch | sLaunch;
    stb.capture = mCapture | sCapture;
    stb.wsChan  = master ? wsChanM : (wsS ^ wsPol);
    stb.sdBit   = master ? sdIn : sdS;
  end

  assign sckOut = sckM;
  assign wsOut  = wsChanM ^ wsPol;
  assign sckOe  = master;
  assign wsOe   = master;
  assign sdOe   = legal && txMode;
endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  asp_strobe_t       stb,
  input  logic              txMode,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              sdOut,
  output logic              underrun
);
  logic wsPrev, wsPrevOk, wsChange;
  logic [WORD_W-2:0] rxSr;
  logic [WORD_W-1:0] wordIn, firstWord;
  logic haveFirst;

  assign wsChange = stb.capture && wsPrevOk && (stb.wsChan != wsPrev);
  assign wordIn   = {rxSr, stb.sdBit};

  // Receive side and framing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wsPrev    <= 1'b0;
      wsPrevOk  <= 1'b0;
      rxSr      <= '0;
      firstWord <= '0;
      haveFirst <= 1'b0;
      rxLeft    <= '0;
      rxRight   <= '0;
      rxValid   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (stb.restart) begin
        wsPrevOk  <= 1'b0;
        haveFirst <= 1'b0;
      end else if (stb.capture) begin
        rxSr     <= wordIn[WORD_W-2:0];
        wsPrev   <= stb.wsChan;
        wsPrevOk <= 1'b1;
        if (wsChange && !txMode) begin
          if (stb.wsChan) begin
            firstWord <= wordIn;
            haveFirst <= 1'b1;
          end else if (haveFirst) begin
            rxLeft    <= firstWord;
            rxRight   <= wordIn;
            rxValid   <= 1'b1;
            haveFirst <= 1'b0;
          end
        end
      end
    end
  end

  // Transmit holding register
  logic holdFull, accept, intoFirst;
  logic [WORD_W-1:0] holdL, holdR, activeR, txSr;
  logic sdOutR;

  assign txReady   = !holdFull;
  assign accept    = txValid && !holdFull;
  assign intoFirst = wsChange && txMode && !stb.wsChan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdL    <= '0;
      holdR    <= '0;
    end else if (accept) begin
      holdFull <= 1'b1;
      holdL    <= txLeft;
      holdR    <= txRight;
    end else if (intoFirst) begin
      holdFull <= 1'b0;
    end
  end

  // Transmit shifter
  always_ff @(posedge clk) begin
    if (!rstN || stb.restart) begin
      txSr     <= '0;
      activeR  <= '0;
      sdOutR   <= 1'b0;
      underrun <= 1'b0;
    end else if (wsChange && txMode) begin
      if (!stb.wsChan) begin
        if (holdFull) begin
          txSr    <= holdL;
          activeR <= holdR;
        end else begin
          txSr     <= '0;
          activeR  <= '0;
          underrun <= 1'b1;
        end
      end else begin
        txSr <= activeR;
      end
    end else if (stb.launch && txMode) begin
      sdOutR <= txSr[WORD_W-1];
      txSr   <= {txSr[WORD_W-2:0], 1'b0};
    end
  end

  assign sdOut = sdOutR;
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [15:0]       ctrlWdata,
  output logic [15:0]       ctrlQ,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              wsIn,
  output logic              wsOut,
  output logic              wsOe,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              underrun,
  output logic              cfgErr
);
  asp_strobe_t stb;
  logic txMode;

  asp_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlQ(ctrlQ),
    .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .sckOut(sckOut), .sckOe(sckOe), .wsOut(wsOut), .wsOe(wsOe), .sdOe(sdOe),
    .txMode(txMode), .cfgErr(cfgErr), .stb(stb)
  );

  asp_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .txMode(txMode),
    .txValid(txValid), .txReady(txReady), .txLeft(txLeft), .txRight(txRight),
    .rxValid(rxValid), .rxLeft(rxLeft), .rxRight(rxRight),
    .sdOut(sdOut), .underrun(underrun)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWe,
  input logic [15:0] ctrlQ,
  input logic        sckOe,
  input logic        wsOe,
  input logic        sdOe,
  input logic        txValid,
  input logic        txReady,
  input logic        rxValid,
  input logic        underrun,
  input logic        cfgErr
);
  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[15] != ctrlQ[14]) |-> !(sckOe || wsOe || sdOe));
  // R9
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[15] != ctrlQ[14]) |=> cfgErr);
  // R9
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  // R10
  rx_in_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !ctrlQ[0]);
  // R10
  sd_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[0] |-> !sdOe);
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !ctrlWe) |=> underrun);
  // R2
  master_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe || wsOe) |-> (ctrlQ[15] && ctrlQ[14]));
endmodule

bind audio_serial_port asp_checker chk_i (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlQ(ctrlQ),
  .sckOe(sckOe), .wsOe(wsOe), .sdOe(sdOe),
  .txValid(txValid), .txReady(txReady), .rxValid(rxValid),
  .underrun(underrun), .cfgErr(cfgErr)
);

// File: tb/audio_serial_port_tb_top.sv
module audio_serial_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [15:0] ctrlWdata = '0;
  logic [15:0] ctrlQ;
  logic sckIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic sckOut, sckOe, wsOut, wsOe, sdOut, sdOe;
  logic txValid = 1'b0, txReady;
  logic [15:0] txLeft = '0, txRight = '0;
  logic rxValid;
  logic [15:0] rxLeft, rxRight;
  logic underrun, cfgErr;

  int checkCnt = 0;
  int failCnt = 0;
  logic [31:0] txExp[$];
  logic [31:0] rxExp[$];

  always #5 clk = ~clk;

  audio_serial_port dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlQ(ctrlQ),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .wsIn(wsIn), .wsOut(wsOut), .wsOe(wsOe),
    .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe),
    .txValid(txValid), .txReady(txReady), .txLeft(txLeft), .txRight(txRight),
    .rxValid(rxValid), .rxLeft(rxLeft), .rxRight(rxRight),
    .underrun(underrun), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pairVal(input int seed);
    logic [15:0] l, r;
    l = 16'h8421 + 16'(seed * 16'h1357);
    r = ~l ^ 16'h0F0F;
    return {l, r};
  endfunction

  task automatic writeCtrl(input logic [15:0] v);
    @(negedge clk);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 1'b0;
    chk(ctrlQ == v, "R1 readback", 32'(ctrlQ), 32'(v));
  endtask

  // Receive scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (rxExp.size() == 0) begin
        chk(1'b0, "R10 unexpected rxValid", {rxLeft, rxRight}, 32'h0);
      end else begin
        logic [31:0] e;
        e = rxExp.pop_front();
        chk({rxLeft, rxRight} == e, "R6 rx pair", {rxLeft, rxRight}, e);
      end
    end
  end

  task automatic masterTx(input logic pol, input logic wsp, input int half, input int n);
    int halfEff;
    halfEff = (half < 2) ? 2 : half;
    writeCtrl({1'b1, 1'b1, pol, wsp, 4'(half), 7'b0, 1'b1});
    chk(wsOut == wsp, "R4 first channel level", 32'(wsOut), 32'(wsp));
    chk(sckOe && wsOe && sdOe, "R2 enables", {29'b0, sckOe, wsOe, sdOe}, 32'h7);
    fork
      begin : drv
        for (int k = 0; k < n; k++) begin
          while (!txReady) @(negedge clk);
          txValid = 1'b1;
          {txLeft, txRight} = pairVal(k + half);
          txExp.push_back(pairVal(k + half));
          @(negedge clk);
          txValid = 1'b0;
          chk(!txReady, "R7 ready drops", 32'(txReady), 32'h0);
        end
      end
      begin : mon
        logic pS, pW, pD, prevCh, ch, havePrev, started;
        logic [15:0] sr, firstW, word;
        int cyc, lastCap, bits, pairs;
        pS = sckOut; pW = wsOut; pD = sdOut;
        havePrev = 0; started = 0; prevCh = 0;
        sr = '0; firstW = '0; word = '0;
        cyc = 0; lastCap = -1; bits = 0; pairs = 0;
        while (pairs < n + 1 && cyc < 20000) begin
          @(negedge clk);
          cyc++;
          if (wsOut != pW || sdOut != pD)
            chk(sckOut != pS && sckOut == pol, "R3 change edge", {31'b0, sckOut}, 32'(pol));
          if (sckOut != pS && sckOut != pol) begin
            if (lastCap >= 0)
              chk(cyc - lastCap == 2 * halfEff, "R2 bit period", 32'(cyc - lastCap), 32'(2 * halfEff));
            lastCap = cyc;
            bits++;
            ch = wsOut ^ wsp;
            if (havePrev && ch != prevCh) begin
              word = {sr[14:0], sdOut};
              if (started) chk(bits == 16, "R2 word select span", 32'(bits), 32'd16);
              if (ch) begin
                firstW = word;
              end else begin
                if (started) begin
                  if (txExp.size() > 0) begin
                    logic [31:0] e;
                    e = txExp.pop_front();
                    chk({firstW, word} == e, "R5 tx pair", {firstW, word}, e);
                    if (txExp.size() > 0) chk(!underrun, "R8 no underrun", 32'(underrun), 32'h0);
                  end else begin
                    chk({firstW, word} == 32'h0, "R8 zero pair", {firstW, word}, 32'h0);
                    chk(underrun, "R8 underrun flag", 32'(underrun), 32'h1);
                  end
                  pairs++;
                end
                started = 1;
              end
              bits = 0;
            end
            sr = {sr[14:0], sdOut};
            prevCh = ch;
            havePrev = 1;
          end
          pS = sckOut; pW = wsOut; pD = sdOut;
        end
        chk(pairs == n + 1, "R5 pair count", 32'(pairs), 32'(n + 1));
      end
    join
  endtask

  task automatic slaveRx(input logic pol, input logic wsp, input int n);
    logic [15:0] wd[16];
    logic wc[16];
    int nw;
    nw = 2 * n + 2;
    writeCtrl({2'b00, pol, wsp, 4'd0, 8'h00});
    chk(!sckOe && !wsOe && !sdOe, "R10 rx mode undriven", {29'b0, sckOe, wsOe, sdOe}, 32'h0);
    wd[0] = '0; wc[0] = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic [31:0] p;
      p = pairVal(k + 7 * n + (pol ? 3 : 0));
      wd[1 + 2 * k] = p[31:16]; wc[1 + 2 * k] = 1'b0;
      wd[2 + 2 * k] = p[15:0];  wc[2 + 2 * k] = 1'b1;
      rxExp.push_back(p);
    end
    wd[nw - 1] = '0; wc[nw - 1] = 1'b0;
    @(negedge clk);
    sckIn = ~pol; wsIn = wc[0] ^ wsp; sdIn = 1'b0;
    repeat (6) @(negedge clk);
    for (int t = 0; t < 16 * nw; t++) begin
      @(negedge clk);
      sckIn = pol;
      sdIn = wd[t / 16][15 - (t % 16)];
      wsIn = ((t + 1 < 16 * nw) ? wc[(t + 1) / 16] : 1'b0) ^ wsp;
      repeat (8) @(negedge clk);
      sckIn = ~pol;
      repeat (7) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(rxExp.size() == 0, "R6 all pairs received", 32'(rxExp.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checkCnt, checkCnt);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R2 reset state
    chk(ctrlQ == 16'h0, "R1 reset value", 32'(ctrlQ), 32'h0);
    chk(!sckOe && !wsOe && !sdOe, "R2 reset enables", {29'b0, sckOe, wsOe, sdOe}, 32'h0);
    chk(txReady && !rxValid && !underrun && !cfgErr, "R7 reset flags",
        {28'b0, txReady, rxValid, underrun, cfgErr}, 32'h8);

    masterTx(1'b0, 1'b0, 2, 4);
    masterTx(1'b1, 1'b1, 3, 3);
    masterTx(1'b0, 1'b1, 0, 2);   // half field below minimum
    chk(!cfgErr, "R9 no error on legal settings", 32'(cfgErr), 32'h0);

    writeCtrl(16'h0000);
    chk(!underrun, "R8 cleared by control write", 32'(underrun), 32'h0);

    slaveRx(1'b0, 1'b0, 3);
    slaveRx(1'b1, 1'b1, 3);
    writeCtrl(16'h00FE);          // reserved bits stored, slave receive
    chk(!sckOe && !sdOe, "R1 reserved bits inert", {30'b0, sckOe, sdOe}, 32'h0);

    // R9 mixed direction pair
    writeCtrl(16'h8001);
    @(negedge clk);
    chk(!sckOe && !wsOe && !sdOe, "R9 outputs released", {29'b0, sckOe, wsOe, sdOe}, 32'h0);
    chk(cfgErr, "R9 error set", 32'(cfgErr), 32'h1);
    repeat (40) @(negedge clk);
    chk(sdOut == 1'b0 && !rxValid, "R9 nothing moves", {30'b0, sdOut, rxValid}, 32'h0);
    writeCtrl(16'h4000);
    chk(!wsOe && !sckOe, "R9 second mixed pair released", {30'b0, wsOe, sckOe}, 32'h0);
    writeCtrl(16'hC001);
    repeat (2) @(negedge clk);
    chk(cfgErr, "R9 error sticky", 32'(cfgErr), 32'h1);
    chk(sckOe && wsOe, "R2 legal again", {30'b0, sckOe, wsOe}, 32'h3);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule